// File: doc/BRIEF.md
# Configurable Width Timer Counter

This block is a timer/counter that runs either as a single 8-bit counter or as two 8-bit lanes cascaded into one 16-bit counter. It advances by one on every cycle in which the external prescaler tick is high and the clock-select field is non-zero. Depending on the mode it either free-runs to its maximum and rolls over, or returns to zero after reaching a compare value built from one or two 8-bit compare registers. The input-capture modes keep the count running exactly as the matching free-running mode does.

Software may load the count at any time, and a load wins over anything else the counter would do in that cycle. The block has two sticky flags. An overflow flag is raised when the count rolls over from its full-scale value. A compare flag is raised when a clear-on-compare mode returns to zero. Each flag is cleared by a write-one pulse. The overflow flag, gated by an enable, drives the interrupt request.

Top module: `flexcnt_timer`

## Requirements
- R1: After a synchronous active-low reset, `count` is 0x0000 and `ovf_flag`, `cmp_flag` and `irq` are 0.
- R2: With mode bits {cap_en,wide,wave} = 000, the low byte counts up by one per enabled tick and goes from 0xFF to 0x00. The high byte keeps its value.
- R3: With mode bits 010, the full 16-bit count increments. The low byte carries into the high byte, and the count goes from 0xFFFF to 0x0000.
- R4: With mode bits 001, the limit is `cmp_a`. An enabled tick taken while the low byte equals that limit sets the low byte to 0x00 and raises `cmp_flag` on the same clock edge.
- R5: With mode bits 011, the limit is {cmp_b, cmp_a} (cmp_b is the high byte). An enabled tick taken at that limit sets the count to 0x0000 and raises `cmp_flag`.
- R6: `ovf_flag` is raised on the edge where an enabled tick moves the count off its full-scale value (0xFF in 8-bit modes, 0xFFFF in 16-bit modes). A compare clear below full scale does not raise it.
- R7: Each flag stays high until a one is written to its clear input (`ovf_clr`, `cmp_clr`). When a set and a clear fall in the same cycle, the set wins.
- R8: When `clk_sel` is 000, ticks are ignored and the count holds. A software load still takes effect.
- R9: When `cnt_wr_en` is high, the count takes `cnt_wr_data` on the next edge, regardless of tick, wrap or compare clear. No flag is raised in that cycle.
- R10: `irq` is high exactly when `ovf_flag` and `ovf_ie` are both high.
- R11: Mode bits 100 count like mode 000, and 110 count like mode 010. The unused codes 101 and 111 behave as mode 000, so `cmp_a` has no effect in them.
- R12: A change to `cmp_a` or `cmp_b` applies from the very next tick, with no staging register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable from the external prescaler |
| clk_sel | input | 3 | Clock source select; 000 stops counting |
| cap_en | input | 1 | Mode bit: capture enable |
| wide | input | 1 | Mode bit: 16-bit width |
| wave | input | 1 | Mode bit: clear on compare |
| cmp_a | input | 8 | Compare register A (low byte of limit) |
| cmp_b | input | 8 | Compare register B (high byte of 16-bit limit) |
| cnt_wr_en | input | 1 | Software load strobe for the count |
| cnt_wr_data | input | 16 | Value loaded into the count |
| ovf_clr | input | 1 | Write-one clear of the overflow flag |
| cmp_clr | input | 1 | Write-one clear of the compare flag |
| ovf_ie | input | 1 | Overflow interrupt enable |
| count | output | 16 | Current count value |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare-match flag |
| irq | output | 1 | Overflow interrupt request |

## Verification
The embedded properties assume that every input is synchronous to `clk` and settles before the edge, and that the mode bits and compare registers do not glitch within a cycle. The stopped-counter property also assumes that ticks arriving while `clk_sel` is zero are legal and must simply be ignored. The directed stimulus changes inputs only on the falling edge and keeps the mode steady around each scenario. Ticks and loads are pulsed for whole cycles, so every registered effect is read half a cycle after the edge that produced it.

// File: rtl/flexcnt_pkg.sv
`timescale 1ns/1ps
// Package: shared mode type and mode-bit decode for the timer/counter.
// Assumes the three mode bits are ordered {capture, width, waveform}.
package flexcnt_pkg;

    typedef enum logic [2:0] {
        MODE_FREE8  = 3'd0,
        MODE_CLR8   = 3'd1,
        MODE_FREE16 = 3'd2,
        MODE_CLR16  = 3'd3,
        MODE_CAP8   = 3'd4,
        MODE_CAP16  = 3'd5
    } cnt_mode_e;

    // Map the raw mode bits to a mode; unused codes fall back to 8-bit free run.
    function automatic cnt_mode_e decode_mode(input logic cap, input logic wid, input logic wav);
        case ({cap, wid, wav})
            3'b000:  decode_mode = MODE_FREE8;
            3'b001:  decode_mode = MODE_CLR8;
            3'b010:  decode_mode = MODE_FREE16;
            3'b011:  decode_mode = MODE_CLR16;
            3'b100:  decode_mode = MODE_CAP8;
            3'b110:  decode_mode = MODE_CAP16;
            default: decode_mode = MODE_FREE8;
        endcase
    endfunction

endpackage

// File: rtl/flexcnt_mode_dec.sv
`timescale 1ns/1ps
// Module: flexcnt_mode_dec
// Turns the mode bits and compare registers into the lane width, the
// clear-on-compare enable and the limit/full-scale values. Purely combinational;
// assumes compare registers are used directly (no staging).
module flexcnt_mode_dec #(
    parameter int LANE_W = 8,
    localparam int CNT_W = 2 * LANE_W
) (
    input  logic              cap_en,
    input  logic              wide,
    input  logic              wave,
    input  logic [LANE_W-1:0] cmp_a,
    input  logic [LANE_W-1:0] cmp_b,
    output logic              is_wide,
    output logic              is_clr,
    output logic [CNT_W-1:0]  top_val,
    output logic [CNT_W-1:0]  max_val
);
    import flexcnt_pkg::*;

    cnt_mode_e mode;

    // Decode mode into width and clear-on-compare attributes.
    always_comb begin
        mode    = decode_mode(cap_en, wide, wave);
        is_wide = (mode == MODE_FREE16) || (mode == MODE_CLR16) || (mode == MODE_CAP16);
        is_clr  = (mode == MODE_CLR8) || (mode == MODE_CLR16);
    end

    // Select full-scale and limit values for the active width.
    always_comb begin
        max_val = is_wide ? {CNT_W{1'b1}} : {{LANE_W{1'b0}}, {LANE_W{1'b1}}};
        if (is_clr)
            top_val = is_wide ? {cmp_b, cmp_a} : {{LANE_W{1'b0}}, cmp_a};
        else
            top_val = max_val;
    end

endmodule

// File: rtl/flexcnt_core.sv
`timescale 1ns/1ps
// Module: flexcnt_core
// The count register built from two cascaded lanes. Handles load priority,
// increment, rollover and clear-on-compare, and reports rollover/compare events.
// Assumes the upper lane is held whenever the 8-bit width is selected.
module flexcnt_core #(
    parameter int LANE_W = 8,
    localparam int NLANE = 2,
    localparam int CNT_W = NLANE * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             is_wide,
    input  logic             is_clr,
    input  logic [CNT_W-1:0] top_val,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count,
    output logic             wrap_evt,
    output logic             match_evt
);
    logic [NLANE:0]     carry;
    logic [CNT_W-1:0]   inc_val;
    logic               at_top;
    logic               at_max;

    assign carry[0] = 1'b1;

    // Per-lane increment: each lane steps when all lanes below it are full.
    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        logic [LANE_W-1:0] lane;
        logic              lane_en;
        assign lane    = count[l*LANE_W +: LANE_W];
        assign lane_en = carry[l] && ((l == 0) || is_wide);
        assign inc_val[l*LANE_W +: LANE_W] = lane_en ? lane + 1'b1 : lane;
        assign carry[l+1] = carry[l] && (&lane);
    end

    // Compare the active width against the limit and full-scale points.
    always_comb begin
        if (is_wide) begin
            at_top = (count == top_val);
            at_max = &count;
        end else begin
            at_top = (count[LANE_W-1:0] == top_val[LANE_W-1:0]);
            at_max = &count[LANE_W-1:0];
        end
    end

    assign wrap_evt  = advance && !wr_en && at_max;
    assign match_evt = advance && !wr_en && is_clr && at_top;

    // Count register: load first, then clear on limit, then plain increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (wr_en)
            count <= wr_data;
        else if (advance) begin
            if (is_clr && at_top)
                count <= is_wide ? '0 : {count[CNT_W-1:LANE_W], {LANE_W{1'b0}}};
            else
                count <= inc_val;
        end
    end

    // R9: a load is taken as-is on the next edge.
    a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (count == $past(wr_data)));

    // R8: no advance and no load means the count holds.
    a_r8_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !wr_en) |=> $stable(count));

    // R4/R5: a compare clear leaves the active lanes at zero.
    a_r4_clear_on_limit: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> (count[LANE_W-1:0] == '0));

endmodule

// File: rtl/flexcnt_flags.sv
`timescale 1ns/1ps
// Module: flexcnt_flags
// Sticky overflow and compare flags with write-one clear, plus the gated
// interrupt request. Assumes a set outranks a clear in the same cycle.
module flexcnt_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_evt,
    input  logic match_evt,
    input  logic ovf_clr,
    input  logic cmp_clr,
    input  logic ovf_ie,
    output logic ovf_flag,
    output logic cmp_flag,
    output logic irq
);
    // Overflow flag: set on rollover, cleared by a write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)        ovf_flag <= 1'b0;
        else if (wrap_evt) ovf_flag <= 1'b1;
        else if (ovf_clr)  ovf_flag <= 1'b0;
    end

    // Compare flag: set on compare clear, cleared by a write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)         cmp_flag <= 1'b0;
        else if (match_evt) cmp_flag <= 1'b1;
        else if (cmp_clr)   cmp_flag <= 1'b0;
    end

    // Interrupt request follows the enabled overflow flag.
    assign irq = ovf_flag && ovf_ie;

    // R6: a rollover event always leaves the flag raised.
    a_r6_ovf_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |=> ovf_flag);

    // R7: without a clear the flag cannot drop.
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    // R7: compare flag is sticky as well.
    a_r7_cmp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag && !cmp_clr) |=> cmp_flag);

endmodule

// File: rtl/flexcnt_timer.sv
`timescale 1ns/1ps
// Module: flexcnt_timer (top)
// Configurable 8/16-bit timer/counter. Gates the prescaler tick with the
// clock-select field and ties together mode decode, count core and flags.
// Assumes all inputs are synchronous to clk.
module flexcnt_timer #(
    parameter int LANE_W = 8,
    parameter int SEL_W  = 3,
    localparam int CNT_W = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [SEL_W-1:0]  clk_sel,
    input  logic              cap_en,
    input  logic              wide,
    input  logic              wave,
    input  logic [LANE_W-1:0] cmp_a,
    input  logic [LANE_W-1:0] cmp_b,
    input  logic              cnt_wr_en,
    input  logic [CNT_W-1:0]  cnt_wr_data,
    input  logic              ovf_clr,
    input  logic              cmp_clr,
    input  logic              ovf_ie,
    output logic [CNT_W-1:0]  count,
    output logic              ovf_flag,
    output logic              cmp_flag,
    output logic              irq
);
    logic             advance;
    logic             is_wide;
    logic             is_clr;
    logic [CNT_W-1:0] top_val;
    logic [CNT_W-1:0] max_val;
    logic             wrap_evt;
    logic             match_evt;

    // A tick counts only when a clock source is selected.
    assign advance = tick && (clk_sel != '0);

    flexcnt_mode_dec #(.LANE_W(LANE_W)) u_dec (
        .cap_en  (cap_en),
        .wide    (wide),
        .wave    (wave),
        .cmp_a   (cmp_a),
        .cmp_b   (cmp_b),
        .is_wide (is_wide),
        .is_clr  (is_clr),
        .top_val (top_val),
        .max_val (max_val)
    );

    flexcnt_core #(.LANE_W(LANE_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .is_wide   (is_wide),
        .is_clr    (is_clr),
        .top_val   (top_val),
        .wr_en     (cnt_wr_en),
        .wr_data   (cnt_wr_data),
        .count     (count),
        .wrap_evt  (wrap_evt),
        .match_evt (match_evt)
    );

    flexcnt_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .wrap_evt  (wrap_evt),
        .match_evt (match_evt),
        .ovf_clr   (ovf_clr),
        .cmp_clr   (cmp_clr),
        .ovf_ie    (ovf_ie),
        .ovf_flag  (ovf_flag),
        .cmp_flag  (cmp_flag),
        .irq       (irq)
    );

    // R6: rollover can only be reported from the full-scale value.
    a_r6_wrap_at_max: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |-> ((count & max_val) == max_val));

    // R10: an enabled request is never raised without the overflow flag.
    a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf_flag && ovf_ie));

endmodule

// File: tb/flexcnt_timer_tb.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module flexcnt_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [2:0]  clk_sel = 3'b001;
    logic        cap_en = 1'b0, wide = 1'b0, wave = 1'b0;
    logic [7:0]  cmp_a = 8'h00, cmp_b = 8'h00;
    logic        cnt_wr_en = 1'b0;
    logic [15:0] cnt_wr_data = 16'h0000;
    logic        ovf_clr = 1'b0, cmp_clr = 1'b0, ovf_ie = 1'b0;
    logic [15:0] count;
    logic        ovf_flag, cmp_flag, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    flexcnt_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clk_sel(clk_sel),
        .cap_en(cap_en), .wide(wide), .wave(wave), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data), .ovf_clr(ovf_clr),
        .cmp_clr(cmp_clr), .ovf_ie(ovf_ie), .count(count), .ovf_flag(ovf_flag),
        .cmp_flag(cmp_flag), .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            cyc();
        end
        tick = 1'b0;
    endtask

    task automatic load(input logic [15:0] v);
        cnt_wr_en = 1'b1; cnt_wr_data = v;
        cyc();
        cnt_wr_en = 1'b0;
    endtask

    task automatic set_mode(input logic [2:0] m);
        {cap_en, wide, wave} = m;
    endtask

    task automatic clear_flags();
        ovf_clr = 1'b1; cmp_clr = 1'b1;
        cyc();
        ovf_clr = 1'b0; cmp_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 count", count, 16'h0000);
        chk("R1 ovf", {15'd0, ovf_flag}, 16'd0);
        chk("R1 cmp", {15'd0, cmp_flag}, 16'd0);
        chk("R1 irq", {15'd0, irq}, 16'd0);
    endtask

    task automatic t_free8();
        set_mode(3'b000);
        load(16'h12FE);
        step(1);
        chk("R2 count FF", count, 16'h12FF);
        chk("R6 no ovf yet", {15'd0, ovf_flag}, 16'd0);
        step(1);
        chk("R2 wrap keeps high byte", count, 16'h1200);
        chk("R6 ovf on wrap", {15'd0, ovf_flag}, 16'd1);
        step(2);
        chk("R7 ovf sticky", {15'd0, ovf_flag}, 16'd1);
        clear_flags();
        chk("R7 ovf cleared", {15'd0, ovf_flag}, 16'd0);
    endtask

    task automatic t_free16();
        set_mode(3'b010);
        load(16'h00FF);
        step(1);
        chk("R3 carry", count, 16'h0100);
        chk("R6 no ovf at 8-bit edge", {15'd0, ovf_flag}, 16'd0);
        load(16'hFFFE);
        step(2);
        chk("R3 wrap 16", count, 16'h0000);
        chk("R6 ovf 16", {15'd0, ovf_flag}, 16'd1);
        clear_flags();
    endtask

    task automatic t_clr8();
        set_mode(3'b001); cmp_a = 8'h05;
        load(16'h0003);
        step(2);
        chk("R4 at limit", count, 16'h0005);
        chk("R4 no cmp yet", {15'd0, cmp_flag}, 16'd0);
        step(1);
        chk("R4 cleared", count, 16'h0000);
        chk("R4 cmp flag", {15'd0, cmp_flag}, 16'd1);
        chk("R6 no ovf on clear", {15'd0, ovf_flag}, 16'd0);
        step(1);
        chk("R7 cmp sticky", {15'd0, cmp_flag}, 16'd1);
        clear_flags();
        chk("R7 cmp cleared", {15'd0, cmp_flag}, 16'd0);
    endtask

    task automatic t_clr16();
        set_mode(3'b011); cmp_a = 8'h02; cmp_b = 8'h01;
        load(16'h0101);
        step(1);
        chk("R5 at limit", count, 16'h0102);
        step(1);
        chk("R5 cleared", count, 16'h0000);
        chk("R5 cmp flag", {15'd0, cmp_flag}, 16'd1);
        clear_flags();
    endtask

    task automatic t_live_cmp();
        set_mode(3'b001); cmp_a = 8'h0A;
        load(16'h0003);
        cmp_a = 8'h04;
        step(1);
        chk("R12 count", count, 16'h0004);
        step(1);
        chk("R12 new limit used", count, 16'h0000);
        clear_flags();
    endtask

    task automatic t_stopped();
        set_mode(3'b000);
        load(16'h0030);
        clk_sel = 3'b000;
        step(3);
        chk("R8 held", count, 16'h0030);
        load(16'h0042);
        chk("R8 load while stopped", count, 16'h0042);
        clk_sel = 3'b001;
    endtask

    task automatic t_load_wins();
        set_mode(3'b000);
        load(16'h00FF);
        tick = 1'b1; cnt_wr_en = 1'b1; cnt_wr_data = 16'h0010;
        cyc();
        tick = 1'b0; cnt_wr_en = 1'b0;
        chk("R9 load over wrap", count, 16'h0010);
        chk("R9 no ovf", {15'd0, ovf_flag}, 16'd0);
        set_mode(3'b001); cmp_a = 8'h07;
        load(16'h0007);
        tick = 1'b1; cnt_wr_en = 1'b1; cnt_wr_data = 16'h0021;
        cyc();
        tick = 1'b0; cnt_wr_en = 1'b0;
        chk("R9 load over clear", count, 16'h0021);
        chk("R9 no cmp", {15'd0, cmp_flag}, 16'd0);
    endtask

    task automatic t_irq_and_race();
        set_mode(3'b000); ovf_ie = 1'b0;
        load(16'h00FF);
        tick = 1'b1; ovf_clr = 1'b1;
        cyc();
        tick = 1'b0; ovf_clr = 1'b0;
        chk("R7 set beats clear", {15'd0, ovf_flag}, 16'd1);
        chk("R10 irq masked", {15'd0, irq}, 16'd0);
        ovf_ie = 1'b1;
        #1;
        chk("R10 irq enabled", {15'd0, irq}, 16'd1);
        clear_flags();
        chk("R10 irq drops", {15'd0, irq}, 16'd0);
        ovf_ie = 1'b0;
    endtask

    task automatic t_capture_reserved();
        set_mode(3'b100);
        load(16'h00FF);
        step(1);
        chk("R11 cap8 wraps", count, 16'h0000);
        chk("R11 cap8 ovf", {15'd0, ovf_flag}, 16'd1);
        clear_flags();
        set_mode(3'b110);
        load(16'h00FF);
        step(1);
        chk("R11 cap16 carries", count, 16'h0100);
        set_mode(3'b101); cmp_a = 8'h03;
        load(16'h0003);
        step(1);
        chk("R11 code 101 ignores cmp_a", count, 16'h0004);
        set_mode(3'b111);
        load(16'h34FF);
        step(1);
        chk("R11 code 111 is 8-bit", count, 16'h3400);
        clear_flags();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cyc(); cyc();
        t_reset();
        rst_n = 1'b1;
        cyc();
        t_free8();
        t_free16();
        t_clr8();
        t_clr16();
        t_live_cmp();
        t_stopped();
        t_load_wins();
        t_irq_and_race();
        t_capture_reserved();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule